// File: doc/BRIEF.md
# Serial hold pause controller

This block sits between the pins of a serial memory interface and its command front-end. It samples chip select, serial clock, serial input, the active-low hold pin and a busy flag from the internal operation engine into the system clock domain. It turns serial clock edges into single-cycle enable pulses for the front-end, and it assembles the serial input into bytes, most significant bit first.

When the host pulls hold low while the device is selected and the serial clock is low, serial traffic is paused. Clock edges and input data are then ignored and the serial output enable is dropped, so the output pin floats. A hold edge that arrives while the serial clock is high does not take effect until the clock is next sampled low, and the same applies to release. Deselecting the device clears any hold and the partial byte. A pause leaves the bit position and the partial byte untouched, so the transfer resumes where it stopped. The busy flag from the internal program or erase engine passes through unaffected by hold or selection.

Top module: `shp_hold_pause`

## Requirements
- R1: After reset the outputs rise_en_o, fall_en_o, held_o, so_oe_o, byte_valid_o and engine_run_o are 0 and bit_idx_o is 0.
- R2: While selected (cs_ni=0) and not held, each rising serial clock edge gives exactly one rise_en_o pulse and shifts si_i into the byte, first bit into bit 7. The eighth bit gives a one-cycle byte_valid_o with the whole byte on byte_o, and bit_idx_o counts 0 to 7 and wraps.
- R3: Hold begins when hold_ni is sampled low while cs_ni is low and sck_i is low. While held, held_o is 1, so_oe_o is 0, and no rise_en_o or fall_en_o pulse occurs however sck_i and si_i move.
- R4: A change on hold_ni while sck_i is high changes nothing until sck_i is sampled low, for both entry and release.
- R5: While deselected (cs_ni=1) held_o and so_oe_o are 0 and the partial byte is discarded, so the next byte starts at bit_idx_o 0.
- R6: Across a hold, bit_idx_o and the partial byte stay unchanged, and after release the byte completes with the correct value.
- R7: engine_run_o follows busy_i after the synchroniser latency, whatever the state of hold_ni and cs_ni.
- R8: While selected and not held, each falling serial clock edge gives exactly one fall_en_o pulse, and so_oe_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| cs_ni | input | 1 | Chip select pin, active low |
| sck_i | input | 1 | Serial clock pin |
| si_i | input | 1 | Serial data input pin |
| hold_ni | input | 1 | Hold pin, active low |
| busy_i | input | 1 | Internal operation engine busy flag |
| rise_en_o | output | 1 | One-cycle pulse per accepted rising serial clock edge |
| fall_en_o | output | 1 | One-cycle pulse per accepted falling serial clock edge |
| si_o | output | 1 | Serial input bit aligned with rise_en_o |
| so_oe_o | output | 1 | Serial output enable, 0 means the output floats |
| held_o | output | 1 | Hold state |
| byte_valid_o | output | 1 | One-cycle pulse when a byte is complete |
| byte_o | output | 8 | Last completed byte |
| bit_idx_o | output | 3 | Bits received in the current byte |
| engine_run_o | output | 1 | Busy flag passed on to the engine side |

## Verification
The assertions assume that every pin is held for longer than the synchroniser depth, so each serial clock level is sampled at least once. They also assume that reset lasts long enough to flush the synchronisers. The bench holds each serial clock phase for six system clocks and changes hold_ni and si_i only while the phase is steady. It sweeps every byte value and every hold position within a byte, which keeps the stimulus inside those assumptions.

// File: rtl/shp_pkg.sv
// Shared types for the serial hold pause controller.
package shp_pkg;
    // Raw pin bundle as sampled from the pads.
    typedef struct packed {
        logic cs_n;
        logic sck;
        logic si;
        logic hold_n;
        logic busy;
    } pins_t;

    localparam int PINS_W = $bits(pins_t);
    // Idle pad levels: deselected, clock low, not held.
    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, si: 1'b0, hold_n: 1'b1, busy: 1'b0};
endpackage

// File: rtl/shp_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pins.
// Assumes each pin is steady for longer than STAGES system clocks.
module shp_sync #(
    parameter int W = 5,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift the sampled pins one stage deeper each clock.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                stage_q[s] <= RST_VAL;
            end else begin
                stage_q[s] <= (s == 0) ? d_i : stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/shp_hold_ctrl.sv
// Hold state tracking and serial clock edge gating.
// Hold is updated only while the synchronised clock is low and is
// cleared while deselected; edges are passed on only when selected and
// the next hold state is inactive. Inputs are already synchronised.
module shp_hold_ctrl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_s,
    input  logic sck_s,
    input  logic si_s,
    input  logic hold_s,
    output logic rise_en_o,
    output logic fall_en_o,
    output logic si_o,
    output logic sel_o,
    output logic held_o,
    output logic so_oe_o
);
    logic sck_d;
    logic held_q;
    logic held_nxt;
    logic rise;
    logic fall;
    logic pass;

    // Next hold state: cleared when deselected, follows the pin while clock low.
    always_comb begin
        if (cs_s) begin
            held_nxt = 1'b0;
        end else if (!sck_s) begin
            held_nxt = !hold_s;
        end else begin
            held_nxt = held_q;
        end
    end

    assign rise = sck_s && !sck_d;
    assign fall = !sck_s && sck_d;
    assign pass = !cs_s && !held_nxt;

    // Register hold state, gated edges, aligned data and output enable.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sck_d     <= 1'b0;
            held_q    <= 1'b0;
            rise_en_o <= 1'b0;
            fall_en_o <= 1'b0;
            si_o      <= 1'b0;
            sel_o     <= 1'b0;
            so_oe_o   <= 1'b0;
        end else begin
            sck_d     <= sck_s;
            held_q    <= held_nxt;
            rise_en_o <= rise && pass;
            fall_en_o <= fall && pass;
            si_o      <= si_s;
            sel_o     <= !cs_s;
            so_oe_o   <= pass;
        end
    end

    assign held_o = held_q;
endmodule

// File: rtl/shp_shifter.sv
// Byte assembler: shifts the serial bit in on each accepted rising edge,
// MSB first, and flags a complete word. Clears its position on deselect.
module shp_shifter #(
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic              valid_o,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] shreg_q;
    logic [WORD_W-1:0] shreg_nxt;

    assign shreg_nxt = {shreg_q[WORD_W-2:0], bit_i};

    // Shift, count and publish completed words.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            shreg_q <= '0;
            cnt_o   <= '0;
            valid_o <= 1'b0;
            word_o  <= '0;
        end else begin
            valid_o <= 1'b0;
            if (!sel_i) begin
                cnt_o <= '0;
            end else if (shift_i) begin
                shreg_q <= shreg_nxt;
                if (cnt_o == LAST) begin
                    cnt_o   <= '0;
                    word_o  <= shreg_nxt;
                    valid_o <= 1'b1;
                end else begin
                    cnt_o <= cnt_o + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/shp_hold_pause.sv
// Top of the serial hold pause controller: synchronises the pins, tracks
// hold, gates serial clock edges and assembles bytes. Assumes pins are
// asynchronous to clk_i and change slower than the synchroniser depth.
module shp_hold_pause
    import shp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_ni,
    input  logic              sck_i,
    input  logic              si_i,
    input  logic              hold_ni,
    input  logic              busy_i,
    output logic              rise_en_o,
    output logic              fall_en_o,
    output logic              si_o,
    output logic              so_oe_o,
    output logic              held_o,
    output logic              byte_valid_o,
    output logic [WORD_W-1:0] byte_o,
    output logic [CNT_W-1:0]  bit_idx_o,
    output logic              engine_run_o
);
    pins_t pins_raw;
    pins_t pins_s;
    logic  cs_s;
    logic  sck_s;
    logic  hold_s;
    logic  sel;

    assign pins_raw = '{cs_n: cs_ni, sck: sck_i, si: si_i, hold_n: hold_ni, busy: busy_i};

    shp_sync #(
        .W      (PINS_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PINS_IDLE)
    ) sync_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    assign cs_s   = pins_s.cs_n;
    assign sck_s  = pins_s.sck;
    assign hold_s = pins_s.hold_n;

    shp_hold_ctrl ctrl_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cs_s     (cs_s),
        .sck_s    (sck_s),
        .si_s     (pins_s.si),
        .hold_s   (hold_s),
        .rise_en_o(rise_en_o),
        .fall_en_o(fall_en_o),
        .si_o     (si_o),
        .sel_o    (sel),
        .held_o   (held_o),
        .so_oe_o  (so_oe_o)
    );

    shp_shifter #(
        .WORD_W(WORD_W)
    ) shift_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (sel),
        .shift_i(rise_en_o),
        .bit_i  (si_o),
        .valid_o(byte_valid_o),
        .word_o (byte_o),
        .cnt_o  (bit_idx_o)
    );

    // Pass the engine busy flag on, untouched by hold or selection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            engine_run_o <= 1'b0;
        end else begin
            engine_run_o <= pins_s.busy;
        end
    end
endmodule

// File: rtl/shp_hold_pause_chk.sv
// Checker for shp_hold_pause, bound to its synchronised pin signals and
// outputs. Assumes pins stay steady for longer than the synchroniser.
module shp_hold_pause_chk #(
    parameter int CNT_W = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cs_s,
    input logic             sck_s,
    input logic             rise_en,
    input logic             fall_en,
    input logic             held,
    input logic             so_oe,
    input logic [CNT_W-1:0] bit_idx
);
    // R3: no edge pulses while held.
    assert_no_edge_when_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        held |-> (!rise_en && !fall_en));

    // R3: output enable is off while held.
    assert_oe_off_when_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        held |-> !so_oe);

    // R4: hold only starts while selected with the clock low.
    assert_entry_clock_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(held) |-> $past(!sck_s && !cs_s));

    // R4: hold is released while selected only with the clock low.
    assert_release_clock_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(held) && $past(!cs_s)) |-> $past(!sck_s));

    // R5: deselect clears hold and output enable.
    assert_deselect_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(cs_s) |-> (!held && !so_oe));

    // R6: bit position frozen across a hold.
    assert_position_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (held && $past(held)) |-> $stable(bit_idx));
endmodule

bind shp_hold_pause shp_hold_pause_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_s   (cs_s),
    .sck_s  (sck_s),
    .rise_en(rise_en_o),
    .fall_en(fall_en_o),
    .held   (held_o),
    .so_oe  (so_oe_o),
    .bit_idx(bit_idx_o)
);

// File: tb/shp_hold_pause_tb_top.sv
// Bench for shp_hold_pause: sweeps all byte values, every hold position
// within a byte, hold edges during the high clock phase, deselect and busy.
module shp_hold_pause_tb_top;
    localparam int HP = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       hold_n = 1'b1;
    logic       busy = 1'b0;
    logic       rise_en, fall_en, si_q, so_oe, held, bvalid, eng;
    logic [7:0] byte_q;
    logic [2:0] bit_idx;

    int errors = 0;
    int checks = 0;
    int rise_cnt = 0;
    int fall_cnt = 0;
    int byte_cnt = 0;
    logic [7:0] got_byte = '0;

    always #2.5 clk = ~clk;

    shp_hold_pause dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
        .hold_ni(hold_n), .busy_i(busy), .rise_en_o(rise_en), .fall_en_o(fall_en),
        .si_o(si_q), .so_oe_o(so_oe), .held_o(held), .byte_valid_o(bvalid),
        .byte_o(byte_q), .bit_idx_o(bit_idx), .engine_run_o(eng)
    );

    // Count output pulses away from the active edge.
    always @(negedge clk) begin
        if (rise_en) rise_cnt++;
        if (fall_en) fall_cnt++;
        if (bvalid) begin
            byte_cnt++;
            got_byte = byte_q;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sck = 1'b0; si = b; wait_n(HP);
        sck = 1'b1; wait_n(HP);
        sck = 1'b0; wait_n(HP);
    endtask

    // Pause mid-transfer and wiggle clock and data: nothing may move.
    task automatic pause(input int pos);
        int r0, f0;
        logic [2:0] idx0;
        hold_n = 1'b0; wait_n(HP);
        chk("R3 held", held, 1);
        chk("R3 so_oe", so_oe, 0);
        r0 = rise_cnt; f0 = fall_cnt; idx0 = bit_idx;
        chk("R6 idx at pause", idx0, pos);
        for (int k = 0; k < 3; k++) begin
            si = k[0]; sck = 1'b1; wait_n(HP);
            sck = 1'b0; wait_n(HP);
        end
        busy = 1'b1; wait_n(HP);
        chk("R7 busy while held", eng, 1);
        busy = 1'b0; wait_n(HP);
        chk("R7 idle while held", eng, 0);
        chk("R3 no rise", rise_cnt - r0, 0);
        chk("R3 no fall", fall_cnt - f0, 0);
        chk("R6 idx stable", bit_idx, idx0);
        hold_n = 1'b1; wait_n(HP);
        chk("R6 released", held, 0);
    endtask

    task automatic send_byte(input logic [7:0] v, input int hold_pos);
        int r0, f0, b0;
        r0 = rise_cnt; f0 = fall_cnt; b0 = byte_cnt;
        for (int i = 0; i < 8; i++) begin
            if (i == hold_pos) pause(i);
            send_bit(v[7-i]);
        end
        wait_n(HP);
        chk("R2 byte value", got_byte, v);
        chk("R2 byte count", byte_cnt - b0, 1);
        chk("R2 rise pulses", rise_cnt - r0, 8);
        chk("R8 fall pulses", fall_cnt - f0, 8);
    endtask

    initial begin
        wait_n(2000000);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        // R1: reset values
        chk("R1 rise_en", rise_en, 0);
        chk("R1 fall_en", fall_en, 0);
        chk("R1 held", held, 0);
        chk("R1 so_oe", so_oe, 0);
        chk("R1 byte_valid", bvalid, 0);
        chk("R1 bit_idx", bit_idx, 0);
        chk("R1 engine_run", eng, 0);

        cs_n = 1'b0; wait_n(HP);
        chk("R8 so_oe selected", so_oe, 1);
        // R2 sweep of all byte values without hold
        for (int v = 0; v < 256; v++) send_byte(8'(v), 8);
        // R6 every hold position
        for (int p = 0; p < 8; p++) send_byte(8'(8'hA5 ^ (p * 37)), p);

        // R5: partial byte discarded by deselect
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        chk("R5 partial idx", bit_idx, 3);
        cs_n = 1'b1; wait_n(HP);
        chk("R5 idx cleared", bit_idx, 0);
        chk("R5 so_oe off", so_oe, 0);
        cs_n = 1'b0; wait_n(HP);
        send_byte(8'h3C, 8);

        // R5: deselect clears hold
        hold_n = 1'b0; wait_n(HP);
        chk("R5 held before deselect", held, 1);
        cs_n = 1'b1; wait_n(HP);
        chk("R5 held cleared", held, 0);
        hold_n = 1'b1; wait_n(HP);
        cs_n = 1'b0; wait_n(HP);
        send_byte(8'hC3, 8);

        // R4: hold edges during the high phase wait for clock low
        cs_n = 1'b1; wait_n(HP); cs_n = 1'b0; wait_n(HP);
        sck = 1'b1; wait_n(HP);
        hold_n = 1'b0; wait_n(HP);
        chk("R4 entry deferred", held, 0);
        chk("R4 oe kept", so_oe, 1);
        sck = 1'b0; wait_n(HP);
        chk("R4 entry on low", held, 1);
        sck = 1'b1; wait_n(HP);
        hold_n = 1'b1; wait_n(HP);
        chk("R4 release deferred", held, 1);
        sck = 1'b0; wait_n(HP);
        chk("R4 release on low", held, 0);

        // R7: busy follows while deselected
        cs_n = 1'b1; busy = 1'b1; wait_n(HP);
        chk("R7 busy deselected", eng, 1);
        busy = 1'b0; wait_n(HP);
        chk("R7 idle deselected", eng, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule